// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a memory-mapped watchdog. Its up-counter runs in a slow functional clock domain (`fclk`, nominally about 32 kHz) and is fed by a power-of-two prescaler. Software programs the block from the bus clock domain (`clk`). Every write to the control, load, trigger or key register is posted across to the functional domain. A status flag for that register stays high until the functional side has taken the value and the acknowledge has come back.

The timer only starts or stops when a two-word key pair is written to the key register in the right order. The counter counts up from the load value. Software keeps it alive by writing the trigger register with a value that differs from the previous trigger value; each such write reloads the counter. If the counter is allowed to step past all ones while running, the block raises `wdt_rst` for one functional-clock cycle and reloads the counter.

The write port is a valid/ready stream. `wr_valid`, `wr_addr` and `wr_data` must hold until `wr_ready` is seen high at a rising `clk` edge. `wr_ready` is low only while the addressed register still has a posted write in flight; writes to other registers, and to the non-posted addresses, are taken at once. Reads are combinational from `rd_addr`.

Top module: `wdk_watchdog`

## Requirements
- R1: After reset the status word is 0, the control, load and configuration registers read 0, the timer is stopped and `wdt_rst` stays low.
- R2: Address 0 is read-only and returns the revision code (parameter, default 0x31) in bits 7:0, with zeros above.
- R3: Address 1 is the configuration register. Bit 0 reads back as written and drives `autoidle_en`; all other bits read 0.
- R4: Address 2 is the read-only status word. It has four pending flags: bit 0 for control (address 3), bit 2 for load (address 4), bit 3 for trigger (address 5) and bit 4 for key (address 6). A flag is set in the `clk` cycle after the write is accepted and clears once the crossing completes. While a flag is set, `wr_ready` is low for that address only.
- R5: Writing 0xBBBB and then 0x4444 as consecutive key-register writes starts the timer.
- R6: Writing 0xAAAA and then 0x5555 as consecutive key-register writes stops the timer.
- R7: A key write that is not the expected second word returns the sequence to its idle state. Any word other than 0xBBBB or 0xAAAA written in the idle state is ignored. After either case the full pair must be written again.
- R8: While running, the counter steps up by one per prescaler tick from the load value L. A tick that finds the counter at all ones reloads L and raises `wdt_rst` for exactly one `fclk` cycle. Pulses therefore repeat every 2^CNT_W − L ticks.
- R9: A trigger write reloads the counter from the load register only if its value differs from the last trigger value (0 after reset). A repeated value has no effect.
- R10: Control bit 5 enables the prescaler and bits 4:2 hold exponent P. When enabled, a tick comes every 2^P `fclk` cycles; when disabled, a tick comes every `fclk` cycle.
- R11: While stopped, the counter holds its value and no `wdt_rst` pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| fclk | input | 1 | Slow functional clock |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write accepted when high with `wr_valid` |
| wr_addr | input | 3 | Write register address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | DATA_W | Read data, combinational |
| autoidle_en | output | 1 | Interface-clock auto-idle enable (config bit 0) |
| wdt_rst | output | 1 | One-`fclk`-cycle expiry reset pulse |

## Verification
The timing sweep runs every prescaler exponent, with the prescaler both on and off, against load values that give one and three ticks per period. The measured pulse spacing in `fclk` cycles therefore separates the divide ratio from the counter span, and an off-by-one in either shows as a wrong product. The key sequences are tried in order, reversed, with a stray word in the middle and with a doubled first word, which tells correct ordering apart from matching on a single word. Trigger writes are sent as a stream of changing values and then as a stream of repeated values, which separates reload-on-change from reload-on-every-write. Each posted register is written alone to show that its own flag rises and that back-pressure stays local to that address.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam logic [2:0] A_REV  = 3'd0;
  localparam logic [2:0] A_CFG  = 3'd1;
  localparam logic [2:0] A_STAT = 3'd2;
  localparam logic [2:0] A_CTRL = 3'd3;
  localparam logic [2:0] A_LOAD = 3'd4;
  localparam logic [2:0] A_TRIG = 3'd5;
  localparam logic [2:0] A_KEY  = 3'd6;

  localparam int KEY_W = 16;
  localparam logic [KEY_W-1:0] KEY_RUN1  = 16'hBBBB;
  localparam logic [KEY_W-1:0] KEY_RUN2  = 16'h4444;
  localparam logic [KEY_W-1:0] KEY_HALT1 = 16'hAAAA;
  localparam logic [KEY_W-1:0] KEY_HALT2 = 16'h5555;

  typedef enum logic [1:0] {
    KS_IDLE  = 2'd0,
    KS_RUN1  = 2'd1,
    KS_HALT1 = 2'd2
  } key_st_e;
endpackage

// File: rtl/wdk_xfer.sv
// Posted write crossing: holds the value in the bus domain, toggles a request,
// the functional side sees a one-cycle strobe, and the echoed toggle clears pend.
module wdk_xfer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         fclk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         pend,
  output logic [W-1:0] held,
  output logic         f_strobe
);
  logic       req_t;
  logic [2:0] req_s;
  logic [2:0] ack_s;
  logic       ack_t;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held  <= '0;
      req_t <= 1'b0;
      pend  <= 1'b0;
      ack_s <= '0;
    end else begin
      ack_s <= {ack_s[1:0], ack_t};
      if (wr_en) begin
        held  <= wr_data;
        req_t <= ~req_t;
        pend  <= 1'b1;
      end else if (ack_s[2] ^ ack_s[1]) begin
        pend <= 1'b0;
      end
    end
  end

  always_ff @(posedge fclk or negedge rst_n) begin
    if (!rst_n) req_s <= '0;
    else        req_s <= {req_s[1:0], req_t};
  end

  assign f_strobe = req_s[1] ^ req_s[2];
  assign ack_t    = req_s[2];

  // R4: the posted value must not move while the crossing is in flight
  a_r4_held_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && $past(pend)) |-> $stable(held));
endmodule

// File: rtl/wdk_keyseq.sv
module wdk_keyseq
  import wdk_pkg::*;
(
  input  logic             fclk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic [KEY_W-1:0] word,
  output logic             run
);
  key_st_e st;

  always_ff @(posedge fclk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= KS_IDLE;
      run <= 1'b0;
    end else if (strobe) begin
      st <= KS_IDLE;
      case (st)
        KS_IDLE: begin
          if (word == KEY_RUN1)       st <= KS_RUN1;
          else if (word == KEY_HALT1) st <= KS_HALT1;
        end
        KS_RUN1:  if (word == KEY_RUN2)  run <= 1'b1;
        KS_HALT1: if (word == KEY_HALT2) run <= 1'b0;
        default: ;
      endcase
    end
  end

  // R5: running only begins right after the first start word was seen
  a_r5_start_order: assert property (@(posedge fclk) disable iff (!rst_n)
    $rose(run) |-> $past(st) == KS_RUN1);
  // R6: stopping only follows the first stop word
  a_r6_stop_order: assert property (@(posedge fclk) disable iff (!rst_n)
    $fell(run) |-> $past(st) == KS_HALT1);
  // R7: without a key write the sequence state cannot advance
  a_r7_no_write_hold: assert property (@(posedge fclk) disable iff (!rst_n)
    !strobe |=> $stable(run));
endmodule

// File: rtl/wdk_counter.sv
module wdk_counter #(
  parameter int CNT_W = 32,
  parameter int PTV_W = 3
) (
  input  logic             fclk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pre_en,
  input  logic [PTV_W-1:0] ptv,
  input  logic [CNT_W-1:0] load_val,
  input  logic             reload,
  output logic             expire
);
  localparam int PRE_W = (1 << PTV_W) - 1;

  logic             tick;
  logic [CNT_W-1:0] cnt;
  logic             at_top;

  generate
    if (PTV_W > 0) begin : g_pre
      logic [PRE_W-1:0] pre_cnt;
      logic [PRE_W-1:0] pre_lim;
      assign pre_lim = (PRE_W'(1) << ptv) - PRE_W'(1);
      assign tick    = run && (!pre_en || (pre_cnt >= pre_lim));
      always_ff @(posedge fclk or negedge rst_n) begin
        if (!rst_n)            pre_cnt <= '0;
        else if (!run || tick) pre_cnt <= '0;
        else                   pre_cnt <= pre_cnt + PRE_W'(1);
      end
    end else begin : g_nopre
      logic unused_pre;
      assign unused_pre = pre_en ^ (|ptv);
      assign tick = run;
    end
  endgenerate

  assign at_top = &cnt;

  always_ff @(posedge fclk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      expire <= 1'b0;
    end else begin
      expire <= tick && at_top && !reload;
      if (reload)       cnt <= load_val;
      else if (tick) begin
        if (at_top)     cnt <= load_val;
        else            cnt <= cnt + CNT_W'(1);
      end
    end
  end

  // R8: an expiry pulse only comes from a running timer
  a_r8_expire_running: assert property (@(posedge fclk) disable iff (!rst_n)
    expire |-> $past(run));
  // R8: a tick below the top steps the count by exactly one
  a_r8_count_up: assert property (@(posedge fclk) disable iff (!rst_n)
    (tick && !at_top && !reload) |=> cnt == $past(cnt) + CNT_W'(1));
  // R11: a stopped timer holds its count
  a_r11_frozen: assert property (@(posedge fclk) disable iff (!rst_n)
    (!run && !reload) |=> $stable(cnt));
endmodule

// File: rtl/wdk_watchdog.sv
module wdk_watchdog
  import wdk_pkg::*;
#(
  parameter int         DATA_W = 32,
  parameter int         CNT_W  = 32,
  parameter int         PTV_W  = 3,
  parameter logic [7:0] REV    = 8'h31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fclk,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              autoidle_en,
  output logic              wdt_rst
);
  localparam int CTRL_W = PTV_W + 1;
  localparam int CTRL_HI = PTV_W + 2;

  logic accept;
  logic p_ctrl, p_load, p_trig, p_key;
  logic s_ctrl, s_load, s_trig, s_key;
  logic [CTRL_W-1:0] h_ctrl;
  logic [CNT_W-1:0]  h_load;
  logic [DATA_W-1:0] h_trig;
  logic [KEY_W-1:0]  h_key;
  logic cfg;
  logic [4:0] stat;

  always_comb begin
    case (wr_addr)
      A_CTRL:  wr_ready = !p_ctrl;
      A_LOAD:  wr_ready = !p_load;
      A_TRIG:  wr_ready = !p_trig;
      A_KEY:   wr_ready = !p_key;
      default: wr_ready = 1'b1;
    endcase
  end

  assign accept = wr_valid && wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cfg <= 1'b0;
    else if (accept && wr_addr == A_CFG) cfg <= wr_data[0];
  end
  assign autoidle_en = cfg;

  wdk_xfer #(.W(CTRL_W)) i_x_ctrl (
    .clk(clk), .fclk(fclk), .rst_n(rst_n),
    .wr_en(accept && wr_addr == A_CTRL), .wr_data(wr_data[CTRL_HI:2]),
    .pend(p_ctrl), .held(h_ctrl), .f_strobe(s_ctrl));
  wdk_xfer #(.W(CNT_W)) i_x_load (
    .clk(clk), .fclk(fclk), .rst_n(rst_n),
    .wr_en(accept && wr_addr == A_LOAD), .wr_data(wr_data[CNT_W-1:0]),
    .pend(p_load), .held(h_load), .f_strobe(s_load));
  wdk_xfer #(.W(DATA_W)) i_x_trig (
    .clk(clk), .fclk(fclk), .rst_n(rst_n),
    .wr_en(accept && wr_addr == A_TRIG), .wr_data(wr_data),
    .pend(p_trig), .held(h_trig), .f_strobe(s_trig));
  wdk_xfer #(.W(KEY_W)) i_x_key (
    .clk(clk), .fclk(fclk), .rst_n(rst_n),
    .wr_en(accept && wr_addr == A_KEY), .wr_data(wr_data[KEY_W-1:0]),
    .pend(p_key), .held(h_key), .f_strobe(s_key));

  // functional-clock copies of the posted registers
  logic [CTRL_W-1:0] f_ctrl;
  logic [CNT_W-1:0]  f_load;
  logic [DATA_W-1:0] f_last_trig;
  logic              f_reload;
  logic              f_run;

  always_ff @(posedge fclk or negedge rst_n) begin
    if (!rst_n) begin
      f_ctrl      <= '0;
      f_load      <= '0;
      f_last_trig <= '0;
    end else begin
      if (s_ctrl) f_ctrl      <= h_ctrl;
      if (s_load) f_load      <= h_load;
      if (s_trig) f_last_trig <= h_trig;
    end
  end

  assign f_reload = s_trig && (h_trig != f_last_trig);

  wdk_keyseq i_keyseq (
    .fclk(fclk), .rst_n(rst_n), .strobe(s_key), .word(h_key), .run(f_run));

  wdk_counter #(.CNT_W(CNT_W), .PTV_W(PTV_W)) i_counter (
    .fclk(fclk), .rst_n(rst_n), .run(f_run),
    .pre_en(f_ctrl[CTRL_W-1]), .ptv(f_ctrl[PTV_W-1:0]),
    .load_val(f_load), .reload(f_reload), .expire(wdt_rst));

  assign stat = {p_key, p_trig, p_load, 1'b0, p_ctrl};

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_REV:   rd_data = DATA_W'(REV);
      A_CFG:   rd_data[0] = cfg;
      A_STAT:  rd_data[4:0] = stat;
      A_CTRL:  rd_data[CTRL_HI:2] = h_ctrl;
      A_LOAD:  rd_data = DATA_W'(h_load);
      A_TRIG:  rd_data = h_trig;
      A_KEY:   rd_data = DATA_W'(h_key);
      default: rd_data = '0;
    endcase
  end

  // R4: an accepted posted write raises its own flag on the next edge
  a_r4_load_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_addr == A_LOAD) |=> p_load);
  a_r4_trig_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_addr == A_TRIG) |=> p_trig);
  // R9: a repeated trigger value must leave the reload idle
  a_r9_same_no_reload: assert property (@(posedge fclk) disable iff (!rst_n)
    (s_trig && $stable(f_last_trig) && h_trig == f_last_trig) |-> !i_counter.reload);
endmodule

// File: tb/test_wdk_watchdog.sv
module test_wdk_watchdog;
  logic        clk = 1'b0;
  logic        fclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [2:0]  wr_addr = 3'd0;
  logic [31:0] wr_data = 32'd0;
  logic [2:0]  rd_addr = 3'd0;
  logic [31:0] rd_data;
  logic        autoidle_en;
  logic        wdt_rst;

  always #5  clk  = ~clk;
  always #15 fclk = ~fclk;

  wdk_watchdog i_wdk_watchdog (
    .clk(clk), .rst_n(rst_n), .fclk(fclk),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .autoidle_en(autoidle_en), .wdt_rst(wdt_rst));

  localparam logic [2:0] AREV = 0, ACFG = 1, ASTAT = 2, ACTRL = 3, ALOAD = 4, ATRIG = 5, AKEY = 6;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  int checks = 0;
  int errors = 0;
  int fcyc = 0;
  int pulses = 0;
  int last_t = 0;
  int prev_t = 0;
  int tv = 1000;

  always @(negedge fclk) begin
    fcyc = fcyc + 1;
    if (wdt_rst === 1'b1) begin
      pulses = pulses + 1;
      prev_t = last_t;
      last_t = fcyc;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_valid = 1'b1;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic wait_idle();
    int n = 0;
    rd_addr = ASTAT;
    @(negedge clk);
    while (rd_data != 0 && n < 200) begin
      @(negedge clk);
      n++;
    end
    if (n >= 200) chk(0, "R4 pending never cleared", rd_data, 0);
  endtask

  task automatic wrs(input logic [2:0] a, input logic [31:0] d);
    wr(a, d);
    wait_idle();
  endtask

  task automatic wait_f(input int n);
    repeat (n) @(negedge fclk);
  endtask

  task automatic wait_pulses(input int n, input int limit);
    int base = pulses;
    int k = 0;
    while (pulses < base + n && k < limit) begin
      @(negedge fclk);
      k++;
    end
  endtask

  task automatic start_t(); wrs(AKEY, 32'hBBBB); wrs(AKEY, 32'h4444); endtask
  task automatic stop_t();  wrs(AKEY, 32'hAAAA); wrs(AKEY, 32'h5555); endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int base;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(ASTAT, d); chk(d == 0, "R1 status", d, 0);
    rd(ACTRL, d); chk(d == 0, "R1 ctrl", d, 0);
    rd(ALOAD, d); chk(d == 0, "R1 load", d, 0);
    rd(ACFG, d);  chk(d == 0, "R1 cfg", d, 0);
    wait_f(100);  chk(pulses == 0, "R1 no pulse", pulses, 0);

    // R2 revision
    rd(AREV, d); chk(d == 32'h31, "R2 rev", d, 32'h31);

    // R3 config bit
    wr(ACFG, ONES);
    rd(ACFG, d); chk(d == 1, "R3 cfg set", d, 1);
    chk(autoidle_en == 1'b1, "R3 autoidle", autoidle_en, 1);
    wr(ACFG, 0);
    rd(ACFG, d); chk(d == 0 && autoidle_en == 1'b0, "R3 cfg clear", d, 0);

    // R4 pending flags and local back-pressure
    for (int i = 0; i < 4; i++) begin
      logic [2:0] a;
      logic [31:0] v, fl;
      case (i)
        0: begin a = ACTRL; v = 0;          fl = 32'h01; end
        1: begin a = ALOAD; v = ONES - 63;  fl = 32'h04; end
        2: begin a = ATRIG; v = 1;          fl = 32'h08; end
        default: begin a = AKEY; v = 0;     fl = 32'h10; end
      endcase
      wr(a, v);
      rd(ASTAT, d); chk(d == fl, "R4 own flag", d, fl);
      wr_addr = a; #1 chk(wr_ready == 1'b0, "R4 stall own", wr_ready, 0);
      wr_addr = ACFG; #1 chk(wr_ready == 1'b1, "R4 other ready", wr_ready, 1);
      wait_idle();
      rd(a, d); chk(d == v, "R4 readback", d, v);
    end

    // R11 stopped: no pulses
    base = pulses; wait_f(300);
    chk(pulses == base, "R11 stopped", pulses, base);

    // R7 broken start sequences
    wrs(AKEY, 32'hBBBB); wrs(AKEY, 32'h1234); wrs(AKEY, 32'h4444);
    base = pulses; wait_f(300);
    chk(pulses == base, "R7 stray word", pulses, base);
    wrs(AKEY, 32'hBBBB); wrs(AKEY, 32'hBBBB); wrs(AKEY, 32'h4444);
    base = pulses; wait_f(300);
    chk(pulses == base, "R7 doubled first", pulses, base);
    wrs(AKEY, 32'h4444); wrs(AKEY, 32'hBBBB); wrs(AKEY, 32'h0);
    base = pulses; wait_f(300);
    chk(pulses == base, "R7 reversed", pulses, base);

    // R5 start, R8 period of 64 ticks
    start_t();
    wait_pulses(3, 1000);
    chk(last_t - prev_t == 64, "R5 R8 period", last_t - prev_t, 64);

    // R7 broken stop keeps running
    wrs(AKEY, 32'hAAAA); wrs(AKEY, 32'h5554); wrs(AKEY, 32'h5555);
    base = pulses; wait_f(200);
    chk(pulses > base, "R7 stop broken", pulses, base + 1);

    // R6 stop
    stop_t();
    base = pulses; wait_f(300);
    chk(pulses == base, "R6 stopped", pulses, base);

    // R9 changing triggers keep it alive, repeated ones do not
    start_t();
    wrs(ATRIG, tv); tv++;
    base = pulses;
    for (int i = 0; i < 40; i++) begin wrs(ATRIG, tv); tv++; end
    chk(pulses == base, "R9 changing trigger", pulses, base);
    base = pulses;
    for (int i = 0; i < 40; i++) wrs(ATRIG, tv - 1);
    chk(pulses > base, "R9 repeated trigger", pulses, base + 1);

    // R8 R10 sweep of prescaler and span
    for (int pe = 0; pe < 2; pe++) begin
      for (int p = 0; p < 8; p++) begin
        for (int kk = 0; kk < 2; kk++) begin
          int k, expv;
          k = (kk == 0) ? 1 : 3;
          expv = k * ((pe != 0) ? (1 << p) : 1);
          stop_t();
          wrs(ACTRL, (pe << 5) | (p << 2));
          wrs(ALOAD, ONES - (k - 1));
          wrs(ATRIG, tv); tv++;
          start_t();
          wait_pulses(3, 4000);
          chk(last_t - prev_t == expv, "R8 R10 interval", last_t - prev_t, expv);
        end
      end
    end
    stop_t();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule